// File: doc/BRIEF.md
# CVSD Delta Modulation Encoder

This block turns signed 16-bit audio samples into a continuously variable slope delta (CVSD) bit stream, one bit per data-clock enable. On each enable it compares the present sample with an internal estimate held in an accumulator and emits a single bit. It then moves the estimate up or down by the current step and adapts the step with a syllabic companding rule. The step grows when the recent bits form a run of equal values and decays otherwise.

The length of that run is chosen at run time: 3 equal bits or 4 equal bits. Two control inputs change the operating mode. A low idle input replaces the encoded stream with an exact alternating pattern, and the internal state tracks those bits as a matching decoder would. A low power input stops all activity and releases the output. The serial output is meant for a three-state pad. An output-enable is provided, and it is true only when the block is powered and data output is requested.

A small state machine records the mode. Its states are `ST_SLEEP` (power low), `ST_IDLE` (powered, idle requested) and `ST_ENC` (powered, normal encoding). The named transitions are:
- wake-to-encode (`ST_SLEEP`→`ST_ENC`)
- wake-to-idle (`ST_SLEEP`→`ST_IDLE`)
- idle-release (`ST_IDLE`→`ST_ENC`)
- idle-force (`ST_ENC`→`ST_IDLE`)
- power-down (either active state →`ST_SLEEP`)

Reset puts the machine in `ST_SLEEP`. On the next edge it follows the inputs.

Top module: `cvsd_enc`

## Requirements
- R1: A synchronous reset sets the serial bit to 0, the accumulator to 0, the step to its minimum (16) and empties the run history. The first encoded bit after reset with a sample of 0 is therefore 1.
- R2: In encode mode, each clock edge with `bit_en` high produces exactly one bit, which is 1 when the signed sample is greater than or equal to the accumulator. Without `bit_en`, `ser_bit` holds its value.
- R3: After each produced bit, the accumulator adds the step on a 1 and subtracts it on a 0. The result saturates at +32767 and −32768.
- R4: With `short_run`=1, a step increase happens when the new bit and the two bits before it are equal. This needs at least two earlier bits since reset.
- R5: With `short_run`=0, a step increase needs the new bit and the three bits before it to be equal. This needs at least three earlier bits since reset.
- R6: On a run, the step becomes step + step/4 (integer), capped at 4096. Otherwise it becomes step − step/16, floored at 16.
- R7: While `idle_n` is low and power is on, the produced bits are 0,1,0,1,… starting with 0 at each entry into idle mode, regardless of the sample.
- R8: Idle bits update the accumulator, step and run history exactly as encoded bits would.
- R9: While `pwr_on` is low, `bit_en` has no effect. `ser_bit`, the accumulator, step and history stay frozen, and encoding later resumes from the frozen state.
- R10: `ser_oe` is 1 exactly when `data_en` and `pwr_on` are both 1.
- R11: A change on `idle_n` or `pwr_on` takes effect from the clock edge after the one that samples it. A `bit_en` at the sampling edge still uses the previous mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| bit_en | input | 1 | Data-clock enable; one bit per high cycle |
| sample | input | 16 | Signed audio sample |
| short_run | input | 1 | 1: 3-bit run rule, 0: 4-bit run rule |
| idle_n | input | 1 | Low forces the alternating idle pattern |
| data_en | input | 1 | Requests the serial output to be driven |
| pwr_on | input | 1 | Low puts the block in a frozen quiescent state |
| ser_bit | output | 1 | Serial CVSD bit |
| ser_oe | output | 1 | Drive enable for the three-state pad |

## Verification
The mode register and the bit enable can fall on the same edge. A change on `idle_n` or `pwr_on` and a `bit_en` pulse can be sampled together. The bench provokes this by dropping `idle_n` in the very cycle that carries an enable. It expects that bit to follow the encoding rule, and expects the next enable to give the first idle 0. Long sweeps of constant, ramped and full-scale samples under both run rules are compared bit by bit against an arithmetic model. Sleep and idle intervals are mixed in, so the frozen and idle-tracked state is judged through the bits that follow.

// File: rtl/cvsd_pkg.sv
package cvsd_pkg;
    typedef enum logic [1:0] {
        ST_SLEEP = 2'd0,
        ST_IDLE  = 2'd1,
        ST_ENC   = 2'd2
    } enc_state_e;
endpackage

// File: rtl/cvsd_run_det.sv
// Tracks the last three produced bits and flags a run that includes the new bit.
module cvsd_run_det (
    input  logic clk,
    input  logic rst,
    input  logic upd,
    input  logic bit_in,
    input  logic short_run,
    output logic run
);
    localparam int HIST = 3;

    logic [HIST-1:0] hist_q;   // hist_q[0] is the most recent bit
    logic [1:0]      fill_q;   // earlier bits seen since reset, saturating at 3
    logic            same2;

    always_comb begin
        same2 = (bit_in == hist_q[0]) && (bit_in == hist_q[1]);
        if (short_run)
            run = (fill_q >= 2'd2) && same2;
        else
            run = (fill_q == 2'd3) && same2 && (bit_in == hist_q[2]);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            hist_q <= '0;
            fill_q <= '0;
        end else if (upd) begin
            hist_q <= {hist_q[HIST-2:0], bit_in};
            if (fill_q != 2'd3)
                fill_q <= fill_q + 2'd1;
        end
    end
endmodule

// File: rtl/cvsd_step.sv
// Syllabic step adaptation: grow on a run, decay otherwise, kept within bounds.
module cvsd_step #(
    parameter int W        = 16,
    parameter int STEP_MIN = 16,
    parameter int STEP_MAX = 4096,
    parameter int GROW_SH  = 2,
    parameter int DECAY_SH = 4
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         upd,
    input  logic         run,
    output logic [W-1:0] step
);
    localparam logic [W:0]   MAX_X = (W+1)'(STEP_MAX);
    localparam logic [W-1:0] MIN_V = W'(STEP_MIN);
    localparam logic [W-1:0] MAX_V = W'(STEP_MAX);

    logic [W:0]   grown;
    logic [W-1:0] shrunk;
    logic [W-1:0] step_d;

    always_comb begin
        grown  = {1'b0, step} + ({1'b0, step} >> GROW_SH);
        shrunk = step - (step >> DECAY_SH);
        if (run)
            step_d = (grown > MAX_X) ? MAX_V : grown[W-1:0];
        else
            step_d = (shrunk < MIN_V) ? MIN_V : shrunk;
    end

    always_ff @(posedge clk) begin
        if (rst)
            step <= MIN_V;
        else if (upd)
            step <= step_d;
    end
endmodule

// File: rtl/cvsd_integ.sv
// Saturating reconstruction accumulator.
module cvsd_integ #(
    parameter int W = 16
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                upd,
    input  logic                up,
    input  logic        [W-1:0] step,
    output logic signed [W-1:0] acc
);
    localparam logic signed [W:0] POS_LIM = {2'b00, {(W-1){1'b1}}};
    localparam logic signed [W:0] NEG_LIM = {2'b11, {(W-1){1'b0}}};

    logic signed [W:0]   acc_x;
    logic signed [W:0]   step_x;
    logic signed [W:0]   sum;
    logic signed [W-1:0] acc_d;

    always_comb begin
        acc_x  = {acc[W-1], acc};
        step_x = $signed({1'b0, step});
        sum    = up ? (acc_x + step_x) : (acc_x - step_x);
        if (sum > POS_LIM)
            acc_d = POS_LIM[W-1:0];
        else if (sum < NEG_LIM)
            acc_d = NEG_LIM[W-1:0];
        else
            acc_d = sum[W-1:0];
    end

    always_ff @(posedge clk) begin
        if (rst)
            acc <= '0;
        else if (upd)
            acc <= acc_d;
    end
endmodule

// File: rtl/cvsd_enc.sv
module cvsd_enc
    import cvsd_pkg::*;
#(
    parameter int W        = 16,
    parameter int STEP_MIN = 16,
    parameter int STEP_MAX = 4096,
    parameter int GROW_SH  = 2,
    parameter int DECAY_SH = 4
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                bit_en,
    input  logic signed [W-1:0] sample,
    input  logic                short_run,
    input  logic                idle_n,
    input  logic                data_en,
    input  logic                pwr_on,
    output logic                ser_bit,
    output logic                ser_oe
);
    enc_state_e          state_q, state_d;
    logic                upd;
    logic                new_bit;
    logic                phase_q;
    logic                run;
    logic        [W-1:0] step;
    logic signed [W-1:0] acc;

    // next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_SLEEP: if (pwr_on) state_d = idle_n ? ST_ENC : ST_IDLE;   // wake-to-encode / wake-to-idle
            ST_IDLE:  if (!pwr_on) state_d = ST_SLEEP;                   // power-down
                      else if (idle_n) state_d = ST_ENC;                 // idle-release
            ST_ENC:   if (!pwr_on) state_d = ST_SLEEP;                   // power-down
                      else if (!idle_n) state_d = ST_IDLE;               // idle-force
            default:  state_d = ST_SLEEP;
        endcase
    end

    // state register
    always_ff @(posedge clk) begin
        if (rst)
            state_q <= ST_SLEEP;
        else
            state_q <= state_d;
    end

    // per-state outputs
    always_comb begin
        upd     = 1'b0;
        new_bit = ser_bit;
        unique case (state_q)
            ST_SLEEP: begin
                upd     = 1'b0;
                new_bit = ser_bit;
            end
            ST_IDLE: begin
                upd     = bit_en;
                new_bit = phase_q;
            end
            ST_ENC: begin
                upd     = bit_en;
                new_bit = (sample >= acc);
            end
            default: begin
                upd     = 1'b0;
                new_bit = ser_bit;
            end
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            ser_bit <= 1'b0;
            phase_q <= 1'b0;
        end else begin
            if (upd)
                ser_bit <= new_bit;
            if (state_q != ST_IDLE)
                phase_q <= 1'b0;
            else if (upd)
                phase_q <= ~phase_q;
        end
    end

    assign ser_oe = data_en & pwr_on;

    cvsd_run_det u_run (
        .clk       (clk),
        .rst       (rst),
        .upd       (upd),
        .bit_in    (new_bit),
        .short_run (short_run),
        .run       (run)
    );

    cvsd_step #(
        .W        (W),
        .STEP_MIN (STEP_MIN),
        .STEP_MAX (STEP_MAX),
        .GROW_SH  (GROW_SH),
        .DECAY_SH (DECAY_SH)
    ) u_step (
        .clk  (clk),
        .rst  (rst),
        .upd  (upd),
        .run  (run),
        .step (step)
    );

    cvsd_integ #(
        .W (W)
    ) u_integ (
        .clk  (clk),
        .rst  (rst),
        .upd  (upd),
        .up   (new_bit),
        .step (step),
        .acc  (acc)
    );
endmodule

// File: rtl/cvsd_enc_chk.sv
module cvsd_enc_chk
    import cvsd_pkg::*;
#(
    parameter int W        = 16,
    parameter int STEP_MIN = 16,
    parameter int STEP_MAX = 4096
) (
    input logic                clk,
    input logic                rst,
    input logic                bit_en,
    input logic                pwr_on,
    input logic                ser_bit,
    input logic                ser_oe,
    input logic        [1:0]   state,
    input logic        [W-1:0] step,
    input logic signed [W-1:0] acc
);
    AST_OE_RELEASED: assert property (@(posedge clk) disable iff (rst)
        !pwr_on |-> !ser_oe);                                                   // R10

    AST_BIT_HOLD: assert property (@(posedge clk) disable iff (rst)
        !bit_en |=> $stable(ser_bit));                                          // R2

    AST_STEP_BOUNDS: assert property (@(posedge clk) disable iff (rst)
        (int'(step) >= STEP_MIN) && (int'(step) <= STEP_MAX));                  // R6

    AST_SLEEP_FROZEN: assert property (@(posedge clk) disable iff (rst)
        (state == ST_SLEEP) |=> ($stable(acc) && $stable(step) && $stable(ser_bit))); // R9

    AST_ACC_DIRECTION: assert property (@(posedge clk) disable iff (rst)
        ((state == ST_ENC) && bit_en) |=> (ser_bit ? (acc >= $past(acc)) : (acc <= $past(acc)))); // R3
endmodule

bind cvsd_enc cvsd_enc_chk #(
    .W        (W),
    .STEP_MIN (STEP_MIN),
    .STEP_MAX (STEP_MAX)
) u_chk (
    .clk     (clk),
    .rst     (rst),
    .bit_en  (bit_en),
    .pwr_on  (pwr_on),
    .ser_bit (ser_bit),
    .ser_oe  (ser_oe),
    .state   (state_q),
    .step    (step),
    .acc     (acc)
);

// File: tb/tb_cvsd_enc.sv
module tb_cvsd_enc;
    logic               clk = 1'b0;
    logic               rst = 1'b1;
    logic               bit_en = 1'b0;
    logic signed [15:0] sample = '0;
    logic               short_run = 1'b1;
    logic               idle_n = 1'b1;
    logic               data_en = 1'b1;
    logic               pwr_on = 1'b1;
    logic               ser_bit;
    logic               ser_oe;

    int n_tests = 0;
    int n_fail  = 0;

    // bench model
    int m_acc, m_step, m_fill;
    bit m_h0, m_h1, m_h2;
    bit m_last, m_phase;
    bit b_idle, b_sleep;

    always #10 clk = ~clk;

    cvsd_enc dut (
        .clk(clk), .rst(rst), .bit_en(bit_en), .sample(sample),
        .short_run(short_run), .idle_n(idle_n), .data_en(data_en),
        .pwr_on(pwr_on), .ser_bit(ser_bit), .ser_oe(ser_oe)
    );

    task automatic check(input string req, input int act, input int exp);
        n_tests++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic model_reset();
        m_acc = 0; m_step = 16; m_fill = 0;
        m_h0 = 0; m_h1 = 0; m_h2 = 0;
        m_last = 0; m_phase = 0;
    endtask

    task automatic model_upd(input bit b);
        bit run;
        int s;
        run = (short_run) ? (m_fill >= 2 && b == m_h0 && b == m_h1)
                          : (m_fill >= 3 && b == m_h0 && b == m_h1 && b == m_h2);
        s = b ? m_acc + m_step : m_acc - m_step;
        if (s > 32767) s = 32767;
        if (s < -32768) s = -32768;
        m_acc = s;
        if (run) begin
            m_step = m_step + (m_step >> 2);
            if (m_step > 4096) m_step = 4096;
        end else begin
            m_step = m_step - (m_step >> 4);
            if (m_step < 16) m_step = 16;
        end
        m_h2 = m_h1; m_h1 = m_h0; m_h0 = b;
        if (m_fill < 3) m_fill++;
        m_last = b;
    endtask

    // one enable pulse; expected bit from the bench's mode view
    task automatic pulse(input int s, input string req);
        bit e;
        @(negedge clk);
        sample = 16'(s);
        bit_en = 1'b1;
        if (b_sleep) e = m_last;
        else if (b_idle) begin e = m_phase; m_phase = ~m_phase; model_upd(e); end
        else begin e = (s >= m_acc); model_upd(e); end
        @(negedge clk);
        bit_en = 1'b0;
        check(req, ser_bit, e);
    endtask

    task automatic set_mode(input bit pw, input bit idn);
        @(negedge clk);
        if (!idn && pw && (b_idle == 0 || b_sleep)) m_phase = 0;
        pwr_on = pw; idle_n = idn;
        b_sleep = !pw; b_idle = !idn;
        @(negedge clk);
        @(negedge clk);
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1;
        @(negedge clk);
        @(negedge clk);
        rst = 1'b0;
        model_reset();
        @(negedge clk);
    endtask

    initial begin
        #(20 * 200000);
        n_fail++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        b_idle = 0; b_sleep = 0;
        model_reset();
        do_reset();
        // R1: reset state
        check("R1 reset ser_bit", ser_bit, 0);
        pulse(0, "R1 first bit with zero accumulator");
        pulse(0, "R1");

        // R10: output enable over all combinations
        for (int c = 0; c < 4; c++) begin
            @(negedge clk);
            data_en = c[0]; pwr_on = c[1];
            #1 check("R10 ser_oe", ser_oe, int'(c[0] & c[1]));
        end
        @(negedge clk);
        data_en = 1'b1; pwr_on = 1'b1;
        @(negedge clk);

        // sweeps under both run rules
        for (int alg = 1; alg >= 0; alg--) begin
            short_run = alg[0];
            do_reset();
            // R2/R4/R5 constant level: long runs then hunting
            for (int i = 0; i < 40; i++) pulse(3000, alg ? "R4 const" : "R5 const");
            // R2/R6 ramp
            for (int i = 0; i < 60; i++) pulse(-20000 + i * 700, alg ? "R4 ramp" : "R5 ramp");
            // R2 triangle
            for (int i = 0; i < 64; i++)
                pulse((i % 16 < 8) ? (i % 16) * 2500 : (16 - i % 16) * 2500 - 10000, "R2 tri");
            // R3/R6 full-scale saturation both ways
            for (int i = 0; i < 70; i++) pulse(32767, "R3 pos sat");
            for (int i = 0; i < 70; i++) pulse(-32768, "R3 neg sat");
            // R6 decay after the bursts
            for (int i = 0; i < 80; i++) pulse(0, "R6 decay");
        end

        // R7/R8 idle pattern and state tracking
        short_run = 1'b1;
        do_reset();
        for (int i = 0; i < 10; i++) pulse(12000, "R2 pre-idle");
        set_mode(1, 0);
        for (int i = 0; i < 9; i++) pulse((i % 2) ? 30000 : -30000, "R7 idle pattern");
        set_mode(1, 1);
        for (int i = 0; i < 20; i++) pulse(5000, "R8 resume after idle");
        set_mode(1, 0);
        pulse(-30000, "R7 re-entry starts at 0");
        pulse(-30000, "R7");
        set_mode(1, 1);

        // R9 sleep freeze
        for (int i = 0; i < 5; i++) pulse(20000, "R2 pre-sleep");
        set_mode(0, 1);
        #1 check("R9 ser_oe released", ser_oe, 0);
        for (int i = 0; i < 8; i++) pulse((i % 2) ? -30000 : 30000, "R9 sleep ignores enable");
        set_mode(1, 1);
        for (int i = 0; i < 15; i++) pulse(-4000, "R9 resume from frozen state");

        // R11: mode change and enable on the same edge
        @(negedge clk);
        idle_n = 1'b0;
        sample = 16'(25000);
        bit_en = 1'b1;
        begin
            bit e;
            e = (25000 >= m_acc);
            model_upd(e);
            @(negedge clk);
            bit_en = 1'b0;
            check("R11 same-edge enable keeps old mode", ser_bit, e);
        end
        b_idle = 1; m_phase = 0;
        pulse(25000, "R11 next enable is idle 0");
        pulse(25000, "R11 idle 1");
        set_mode(1, 1);
        @(negedge clk);
        pwr_on = 1'b0;
        sample = 16'(-25000);
        bit_en = 1'b1;
        begin
            bit e;
            e = (-25000 >= m_acc);
            model_upd(e);
            @(negedge clk);
            bit_en = 1'b0;
            check("R11 enable at power-down edge", ser_bit, e);
        end
        b_sleep = 1;
        pulse(25000, "R11 asleep after edge");
        set_mode(1, 1);
        for (int i = 0; i < 6; i++) pulse(1000, "R11 resume");

        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule